// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block routes up to 24 external interrupt request lines to a single outgoing interrupt message channel. Each line has its own 64-bit routing entry. The entry selects a vector, a destination, the trigger style (edge or level), the input polarity and a mask. When a line becomes pending and is not masked, the controller presents a message with the entry's vector and destination on a valid/ready output. Only one message can be outstanding at a time. When several lines are pending together, the line with the lowest index is sent first.

Software sees three 32-bit locations. The first is a select register that holds an 8-bit register index. The second is a data window that reads or writes whatever register the select points at. The third is a write-only location that signals end-of-interrupt. The indexed space holds an identification register, a read-only version register and the routing table. Each routing entry spans two consecutive indices.

A level-triggered line that has been delivered stays blocked by a remote-pending flag. Software clears that flag by writing the delivered vector to the end-of-interrupt location.

Top module: `irt_router`

## Requirements
- R1: After reset, no message is valid and the select register reads 0. Every routing entry's low word reads 0x00010000 (mask set, all other fields zero) and its high word reads 0.
- R2: A write at byte offset 0x00 stores bits 7:0 as the register index, and a read there returns that index in bits 7:0. Offset 0x10 is the data window onto the selected index. A write at offset 0x40 is an end-of-interrupt carrying a vector in bits 7:0. Reads at offsets other than 0x00 and 0x10 return zero.
- R3: Index 0x00 returns the unit identifier in bits 27:24 with all other bits zero, and a window write updates only bits 27:24. Index 0x01 is read-only and returns the version parameter in bits 7:0 and (line count − 1) in bits 23:16, which is 0x17 for 24 lines.
- R4: Entry n's low word is at index 0x10+2n and its high word at 0x10+2n+1. The high word stores only bits 31:24 (the destination), and all its other bits read zero. Indices 0x02–0x0F and 0x40 and above read zero, and writes to them change nothing.
- R5: In the low word, the vector is in bits 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13, remote-pending in 14, trigger mode in 15 (1 = level) and mask in 16. Bits 12 and 14 ignore writes.
- R6: Polarity bit 1 makes a line active-low. The raw input is inverted before detection, so an inactive-low line produces no message.
- R7: In edge mode, a rising edge of the polarity-corrected input on an unmasked line makes the message valid at the first clock edge after the edge is sampled. Holding the input active produces no further message, and a fresh edge produces another one.
- R8: In level mode, an active unmasked line is delivered once and its remote-pending bit (bit 14) is set. It is not delivered again while that bit is set. An end-of-interrupt write with a different vector leaves the bit set. A write with the matching vector clears it, and a line that is still active is then delivered again.
- R9: A line whose mask bit (16) is set produces no message. An edge that arrives while the line is masked is dropped, so unmasking alone does not deliver it.
- R10: When several unmasked lines are pending at once, the lowest-numbered line is delivered first. The others follow one by one after each acceptance.
- R11: While valid is high and ready is low, the vector and destination outputs hold steady. The delivery status bit (12) of the delivered line reads 1 from grant until acceptance and 0 afterwards. No new message is granted while one is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register locations |
| bus_addr | input | 8 | Byte offset: 0x00 select, 0x10 window, 0x40 end-of-interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset (combinational) |
| irq_lines | input | NUM_LINES | Raw interrupt request inputs |
| msg_valid | output | 1 | Interrupt message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Vector of the presented message |
| msg_dest | output | 8 | Destination of the presented message |

## Verification
The assertions check the following on every cycle:
- the output stays stable while the receiver stalls;
- at most one line has delivery status set, and status agrees with the valid output;
- the arbiter's grant is one-hot and never skips a lower pending line;
- a masked line never requests;
- a level line with remote-pending set never requests;
- a line with a message in flight is never granted again.

Other behaviour needs the bench's scenarios:
- the index map and field layout;
- the read-only bits;
- the exact latency from an input edge to a valid message;
- polarity inversion;
- dropping of edges seen while masked;
- matching of end-of-interrupt vectors, and re-delivery after end-of-interrupt.

// File: rtl/irt_pkg.sv
package irt_pkg;

  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] OFS_EOI    = 8'h40;

  localparam logic [7:0] IDX_IDENT  = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_TABLE  = 8'h10;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       active_low;
    logic       dest_logical;
    logic [2:0] dmode;
    logic [7:0] vector;
  } route_t;

  localparam route_t ROUTE_RESET = '{dest: 8'h00, mask: 1'b1, level: 1'b0,
                                     active_low: 1'b0, dest_logical: 1'b0,
                                     dmode: 3'b000, vector: 8'h00};

  // True when the index falls inside the routing table for the given line count
  function automatic logic is_route_idx(logic [7:0] idx, logic [7:0] lines);
    logic [8:0] lo, hi;
    lo = {1'b0, IDX_TABLE};
    hi = {1'b0, IDX_TABLE} + {lines, 1'b0};
    return ({1'b0, idx} >= lo) && ({1'b0, idx} < hi);
  endfunction

  // Entry number addressed by a table index (two indices per entry)
  function automatic logic [7:0] route_slot(logic [7:0] idx);
    logic [7:0] off;
    off = idx - IDX_TABLE;
    return {1'b0, off[7:1]};
  endfunction

  // Software view of the low word, status bits merged in
  function automatic logic [31:0] pack_low(route_t e, logic busy, logic rirr);
    return {15'b0, e.mask, e.level, rirr, e.active_low, busy,
            e.dest_logical, e.dmode, e.vector};
  endfunction

  // Low-word write: status bits 12 and 14 are not stored
  function automatic route_t apply_low(route_t e, logic [31:0] w);
    route_t r;
    r              = e;
    r.vector       = w[7:0];
    r.dmode        = w[10:8];
    r.dest_logical = w[11];
    r.active_low   = w[13];
    r.level        = w[15];
    r.mask         = w[16];
    return r;
  endfunction

endpackage

// File: rtl/irt_line.sv
module irt_line
  import irt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        irq_raw,
  input  logic        grant,
  input  logic        accept,
  input  logic        eoi,
  input  logic [7:0]  eoi_vec,
  output route_t      cfg,
  output logic        busy,
  output logic        rirr,
  output logic        req
);

  route_t cfg_q;
  logic   busy_q, rirr_q, pend_q, seen_q;
  logic   active, rise, eoi_hit;

  assign active  = irq_raw ^ cfg_q.active_low;
  assign rise    = active & ~seen_q;
  assign eoi_hit = eoi & cfg_q.level & (eoi_vec == cfg_q.vector);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= ROUTE_RESET;
      busy_q <= 1'b0;
      rirr_q <= 1'b0;
      pend_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= active;
      if (wr_lo)      cfg_q      <= apply_low(cfg_q, wdata);
      else if (wr_hi) cfg_q.dest <= wdata[31:24];
      pend_q <= (pend_q | (rise & ~cfg_q.level)) & ~grant & ~cfg_q.mask;
      if (grant)       busy_q <= 1'b1;
      else if (accept) busy_q <= 1'b0;
      if (grant && cfg_q.level) rirr_q <= 1'b1;
      else if (eoi_hit)         rirr_q <= 1'b0;
    end
  end

  assign req  = ~cfg_q.mask & ~busy_q &
                (cfg_q.level ? (active & ~rirr_q) : (pend_q | rise));
  assign cfg  = cfg_q;
  assign busy = busy_q;
  assign rirr = rirr_q;

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.mask |-> !req) else $error("masked line requested"); // R9
  AST_RIRR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.level && rirr_q) |-> !req) else $error("level line re-requested"); // R8
  AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !grant) else $error("line granted while in flight"); // R11

endmodule

// File: rtl/irt_prio.sv
module irt_prio #(
  parameter int N  = 24,
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [LW-1:0] idx,
  output logic          any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = en;
        idx      = LW'(i);
      end
    end
  end

  assign any = en && (req != '0);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)) else $error("multiple grants"); // R10
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((req & (grant - N'(1))) == '0)) else $error("lower line skipped"); // R10

endmodule

// File: rtl/irt_router.sv
module irt_router
  import irt_pkg::*;
#(
  parameter int         NUM_LINES = 24,
  parameter logic [3:0] UNIT_ID   = 4'h0,
  parameter logic [7:0] VERSION   = 8'h20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [7:0]           msg_dest
);

  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam logic [7:0] LAST_ENTRY = 8'(NUM_LINES - 1);

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic        wr_sel, wr_win, wr_eoi;
  logic        sel_is_route;
  logic [7:0]  slot;
  logic [LW-1:0] slot_idx;

  route_t            cfg_w [NUM_LINES];
  logic [NUM_LINES-1:0] busy_w, rirr_w, req_w, grant_w, accept_w, wr_lo_w, wr_hi_w;

  logic          grant_any;
  logic [LW-1:0] grant_idx;
  logic          msg_valid_q;
  logic [7:0]    msg_vec_q, msg_dest_q;
  logic [LW-1:0] owner_q;
  logic [31:0]   win_data;

  assign wr_sel       = bus_wr && (bus_addr == OFS_SELECT);
  assign wr_win       = bus_wr && (bus_addr == OFS_WINDOW);
  assign wr_eoi       = bus_wr && (bus_addr == OFS_EOI);
  assign sel_is_route = is_route_idx(sel_q, 8'(NUM_LINES));
  assign slot         = route_slot(sel_q);
  assign slot_idx     = slot[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 8'h00;
      id_q  <= UNIT_ID;
    end else begin
      if (wr_sel) sel_q <= bus_wdata[7:0];
      if (wr_win && sel_q == IDX_IDENT) id_q <= bus_wdata[27:24];
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign wr_lo_w[g]  = wr_win && sel_is_route && (slot_idx == LW'(g)) && !sel_q[0];
    assign wr_hi_w[g]  = wr_win && sel_is_route && (slot_idx == LW'(g)) &&  sel_q[0];
    assign accept_w[g] = msg_valid_q && msg_ready && (owner_q == LW'(g));

    irt_line u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_lo_w[g]),
      .wr_hi   (wr_hi_w[g]),
      .wdata   (bus_wdata),
      .irq_raw (irq_lines[g]),
      .grant   (grant_w[g]),
      .accept  (accept_w[g]),
      .eoi     (wr_eoi),
      .eoi_vec (bus_wdata[7:0]),
      .cfg     (cfg_w[g]),
      .busy    (busy_w[g]),
      .rirr    (rirr_w[g]),
      .req     (req_w[g])
    );
  end

  irt_prio #(.N(NUM_LINES), .LW(LW)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (!msg_valid_q),
    .req   (req_w),
    .grant (grant_w),
    .idx   (grant_idx),
    .any   (grant_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid_q <= 1'b0;
      msg_vec_q   <= 8'h00;
      msg_dest_q  <= 8'h00;
      owner_q     <= '0;
    end else if (msg_valid_q && msg_ready) begin
      msg_valid_q <= 1'b0;
    end else if (grant_any) begin
      msg_valid_q <= 1'b1;
      msg_vec_q   <= cfg_w[grant_idx].vector;
      msg_dest_q  <= cfg_w[grant_idx].dest;
      owner_q     <= grant_idx;
    end
  end

  always_comb begin
    win_data = 32'h0;
    if (sel_q == IDX_IDENT)
      win_data = {4'h0, id_q, 24'h0};
    else if (sel_q == IDX_VER)
      win_data = {8'h00, LAST_ENTRY, 8'h00, VERSION};
    else if (sel_is_route)
      win_data = sel_q[0] ? {cfg_w[slot_idx].dest, 24'h0}
                          : pack_low(cfg_w[slot_idx], busy_w[slot_idx], rirr_w[slot_idx]);
  end

  always_comb begin
    case (bus_addr)
      OFS_SELECT: bus_rdata = {24'h0, sel_q};
      OFS_WINDOW: bus_rdata = win_data;
      default:    bus_rdata = 32'h0;
    endcase
  end

  assign msg_valid  = msg_valid_q;
  assign msg_vector = msg_vec_q;
  assign msg_dest   = msg_dest_q;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_q && !msg_ready) |=> (msg_valid_q && $stable(msg_vec_q) && $stable(msg_dest_q)))
    else $error("message changed while stalled"); // R11
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_w)) else $error("more than one line in flight"); // R11
  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid_q == (busy_w != '0)) else $error("delivery status disagrees with valid"); // R11

endmodule

// File: tb/irt_router_tb.sv
module irt_router_tb_top;

  localparam int         CLK_PERIOD = 10;
  localparam int         LINES      = 24;
  localparam logic [3:0] TB_ID      = 4'h9;
  localparam logic [7:0] TB_VER     = 8'h20;

  // row: line[31:24] vector[23:16] dest[15:8] flags[7:0] (bit0 level, bit1 active-low)
  localparam logic [31:0] ROWS [6] = '{
    32'h00_30_01_00, 32'h07_41_02_01, 32'h0C_52_03_02,
    32'h17_63_04_03, 32'h10_74_A5_00, 32'h03_85_5A_01
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0;
  logic [7:0]       bus_addr = 8'h00;
  logic [31:0]      bus_wdata = 32'h0;
  logic [31:0]      bus_rdata;
  logic [LINES-1:0] irq = '0;
  logic             msg_valid, msg_ready = 1'b0;
  logic [7:0]       msg_vector, msg_dest;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irt_router #(.NUM_LINES(LINES), .UNIT_ID(TB_ID), .VERSION(TB_VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, {24'h0, idx});
    bus_write(8'h10, d);
  endtask

  task automatic win_read(input logic [7:0] idx, output logic [31:0] v);
    bus_write(8'h00, {24'h0, idx});
    bus_addr = 8'h10;
    #1 v = bus_rdata;
  endtask

  task automatic accept_msg();
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic expect_msg(input string tag, input logic [7:0] v, input logic [7:0] d);
    check({tag, " valid"}, {31'h0, msg_valid}, 32'h1);
    check({tag, " vector"}, {24'h0, msg_vector}, {24'h0, v});
    check({tag, " dest"}, {24'h0, msg_dest}, {24'h0, d});
  endtask

  task automatic idle_check(input string tag, input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      check(tag, {31'h0, msg_valid}, 32'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 valid after reset", {31'h0, msg_valid}, 32'h0);
    bus_addr = 8'h00; #1;
    check("R1 select after reset", bus_rdata, 32'h0);
    win_read(8'h10, v); check("R1 entry0 low", v, 32'h00010000);
    win_read(8'h3E, v); check("R1 entry23 low", v, 32'h00010000);
    win_read(8'h3F, v); check("R1 entry23 high", v, 32'h0);

    // R3 identification and version
    win_read(8'h00, v); check("R3 ident reset", v, {4'h0, TB_ID, 24'h0});
    win_read(8'h01, v); check("R3 version", v, {8'h00, 8'(LINES - 1), 8'h00, TB_VER});
    win_write(8'h00, 32'hFFFFFFFF);
    win_read(8'h00, v); check("R3 ident write", v, 32'h0F000000);
    win_write(8'h01, 32'h0);
    win_read(8'h01, v); check("R3 version read-only", v, {8'h00, 8'(LINES - 1), 8'h00, TB_VER});

    // R2 select readback and other offsets
    bus_write(8'h00, 32'hFFFFFF3B);
    bus_addr = 8'h00; #1; check("R2 select readback", bus_rdata, 32'h3B);
    bus_addr = 8'h20; #1; check("R2 unmapped offset", bus_rdata, 32'h0);
    bus_addr = 8'h40; #1; check("R2 eoi reads zero", bus_rdata, 32'h0);

    // R4 reserved indices and table bounds
    win_write(8'h05, 32'hFFFFFFFF);
    win_read(8'h05, v); check("R4 reserved index", v, 32'h0);
    win_write(8'h40, 32'hFFFFFFFF);
    win_read(8'h40, v); check("R4 past table", v, 32'h0);
    win_read(8'h3F, v); check("R4 entry23 high untouched", v, 32'h0);
    win_write(8'h13, 32'hFFFFFFFF);
    win_read(8'h13, v); check("R4 high word dest only", v, 32'hFF000000);

    // R5 field layout, read-only status bits
    win_write(8'h12, 32'h00017FFF);
    win_read(8'h12, v); check("R5 low word status ignored", v, 32'h00012FFF);
    win_write(8'h12, 32'h00010000);
    win_write(8'h13, 32'h0);

    // Table-driven routing: R6 polarity, R7 edge, R8 level, R11 handshake
    for (int r = 0; r < 6; r++) begin
      int          ln;
      logic [7:0]  vec, dst, lo_idx;
      logic        lvl, alow;
      logic [31:0] lo_word;
      ln     = int'(ROWS[r][31:24]);
      vec    = ROWS[r][23:16];
      dst    = ROWS[r][15:8];
      lvl    = ROWS[r][0];
      alow   = ROWS[r][1];
      lo_idx = 8'(8'h10 + 2 * ln);
      lo_word = {15'h0, 1'b0, lvl, 1'b0, alow, 5'h0, vec};

      @(negedge clk); irq[ln] = alow;
      @(negedge clk);
      win_write(lo_idx + 8'h01, {dst, 24'h0});
      win_write(lo_idx, lo_word);
      idle_check("R6 inactive level no message", 2);

      irq[ln] = ~alow;
      @(negedge clk);
      expect_msg("R7 first delivery", vec, dst);
      win_read(lo_idx, v);
      check("R11 status while in flight", v, lo_word | 32'h1000 | (lvl ? 32'h4000 : 32'h0));
      expect_msg("R11 stable while stalled", vec, dst);
      accept_msg();
      check("R11 valid cleared", {31'h0, msg_valid}, 32'h0);
      win_read(lo_idx, v);
      check("R11 status after accept", v & 32'h1000, 32'h0);
      idle_check(lvl ? "R8 held by remote-pending" : "R7 no repeat while held", 3);

      if (lvl) begin
        bus_write(8'h40, {24'h0, vec ^ 8'h01});
        idle_check("R8 wrong eoi no release", 2);
        win_read(lo_idx, v); check("R8 remote-pending kept", v & 32'h4000, 32'h4000);
        bus_write(8'h40, {24'h0, vec});
        check("R8 eoi cycle", {31'h0, msg_valid}, 32'h0);
        @(negedge clk);
        expect_msg("R8 redelivery after eoi", vec, dst);
        accept_msg();
        irq[ln] = alow;
        bus_write(8'h40, {24'h0, vec});
        win_read(lo_idx, v); check("R8 remote-pending cleared", v & 32'h4000, 32'h0);
        idle_check("R8 inactive after eoi", 2);
      end else begin
        irq[ln] = alow;
        @(negedge clk);
        irq[ln] = ~alow;
        @(negedge clk);
        expect_msg("R7 second edge", vec, dst);
        accept_msg();
        irq[ln] = alow;
      end
      win_write(lo_idx, lo_word | 32'h00010000);
    end

    // R9 masked edge dropped
    win_write(8'h23, 32'h11000000);
    win_write(8'h22, 32'h00010099);
    @(negedge clk); irq[9] = 1'b1;
    idle_check("R9 masked no message", 3);
    win_write(8'h22, 32'h00000099);
    idle_check("R9 edge while masked dropped", 2);
    irq[9] = 1'b0; @(negedge clk);
    irq[9] = 1'b1; @(negedge clk);
    expect_msg("R9 after unmask", 8'h99, 8'h11);
    accept_msg();
    irq[9] = 1'b0;
    win_write(8'h22, 32'h00010099);

    // R10 priority, R11 hold under stall
    win_write(8'h14, 32'h00000022);
    win_write(8'h1A, 32'h00000055);
    @(negedge clk); irq[2] = 1'b1; irq[5] = 1'b1;
    @(negedge clk);
    expect_msg("R10 lowest line first", 8'h22, 8'h00);
    repeat (3) @(negedge clk);
    expect_msg("R11 held across stall", 8'h22, 8'h00);
    accept_msg();
    check("R11 gap after accept", {31'h0, msg_valid}, 32'h0);
    @(negedge clk);
    expect_msg("R10 next line", 8'h55, 8'h00);
    accept_msg();
    idle_check("R10 no extra message", 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule